// File: doc/BRIEF.md
# Response Byte Transmitter with Boundary Abort

This block sends the data bytes of a slave's response over a single-wire, open-drain serial bus that rests high. A transfer starts with a one-cycle `start` pulse that also captures how many bytes will follow. The block then asks for each byte in turn with `byte_req`, and the supplier answers with a one-cycle `byte_load`. Each byte goes out as a ten-bit frame. Every bit lasts `bit_period` clock cycles, and the bus is held recessive between frames while the block waits for the next byte.

Because the bus is shared, the block reads back `bus_in` in the middle of every bit it drives. If the value read differs from the value driven, transmission stops at the end of that bit and a sticky error flag is raised.

Software can ask for a transfer to stop through a control bit that can be read back. The block honours the request only at a byte boundary. It then drops the unsent bytes and clears the bit by itself. A write to the bit while no transfer is running leaves it at zero.

Top module: `resp_byte_tx`

## Requirements
- R1: After reset `tx_out` is 1, and `tx_busy`, `tx_done`, `bit_err`, `abort_rd` and `byte_req` are all 0.
- R2: Each frame has three parts, sent in this order:
  - a start bit of 0;
  - the eight data bits, least significant first;
  - a stop bit of 1.

  Each bit lasts exactly `bit_period` cycles, with values below 2 treated as 2. The start bit appears in the cycle after the edge that accepts a byte.
- R3: A `start` pulse while idle with a nonzero `byte_count` makes the block request exactly that many bytes. `byte_req` is high only while the block is waiting for a byte. A byte is taken on `byte_load` while `byte_req` is high, and `tx_out` stays 1 while the block waits. A `start` pulse while busy, or with a count of 0, is ignored.
- R4: When the stop bit of the last byte ends with no abort pending and no error, the transfer ends and `tx_done` goes to 1. `tx_done` returns to 0 on the next accepted `start`.
- R5: An abort request lets the byte being shifted out finish in full. `tx_busy` falls exactly at the end of that byte's stop bit.
- R6: An abort that takes effect returns `abort_rd` to 0 and discards the remaining bytes, which are never requested, and `tx_done` stays 0. While the request is pending, `abort_rd` reads 1.
- R7: A write of 1 to the abort bit (`abort_wr` with `abort_wdata`=1) while `tx_busy` is 0 has no effect, and `abort_rd` stays 0.
- R8: `bus_in` is compared with `tx_out` at elapsed cycle `bit_period/2` of each bit. On a mismatch, `bit_err` goes to 1 and `tx_busy` falls at the end of that same bit. No further bytes are requested and `tx_done` stays 0.
- R9: `bit_err` holds until a cycle with `err_clr`=1, which clears it.
- R10: An abort written in the final cycle of a byte's stop bit is handled according to that byte's position:
  - if more bytes remain, the next byte is not requested and the transfer ends without `tx_done`;
  - if it is the last byte, the transfer completes with `tx_done`=1.

  In both cases `abort_rd` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_period | input | 16 | Cycles per bit (minimum 2) |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| byte_count | input | 4 | Number of bytes in the transfer, captured with `start` |
| byte_req | output | 1 | Block is waiting for the next byte |
| byte_load | input | 1 | Next byte is presented on `byte_data` |
| byte_data | input | 8 | Byte to send |
| abort_wr | input | 1 | Write strobe for the abort bit |
| abort_wdata | input | 1 | Value written to the abort bit |
| abort_rd | output | 1 | Abort bit readback |
| err_clr | input | 1 | Write-1 clear of `bit_err` |
| bit_err | output | 1 | Sticky readback-mismatch flag |
| tx_done | output | 1 | Last transfer completed normally |
| tx_busy | output | 1 | Transfer in progress |
| tx_out | output | 1 | Bus drive; 1 is recessive |
| bus_in | input | 1 | Bus level read back |

## Verification
The two functions that can meet in a single cycle are the abort write and the byte boundary: an abort can land in the very cycle that ends a stop bit. The bench times the write from the recorded cycle in which the byte was loaded, so that it reaches the design on the tenth bit edge. It does this once with bytes still queued and once on the final byte. In the first case it checks that no further byte is requested and that `tx_done` stays low. In the second it checks that the transfer completes with `tx_done` high. In both it checks that the abort bit reads back zero afterwards.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  localparam int FRAME_BITS = 10;
  localparam int IDX_W      = 4;

  // start bit in position 0, stop bit in position 9, data in between
  function automatic logic [FRAME_BITS-1:0] frame_word(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                mid_tick,
  output logic                end_tick
);

  localparam logic [PERIOD_W-1:0] MIN_PERIOD = PERIOD_W'(2);

  function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

  function automatic logic [PERIOD_W-1:0] last_count(input logic [PERIOD_W-1:0] p);
    return eff_period(p) - PERIOD_W'(1);
  endfunction

  // counting down: elapsed cycles = last_count - cnt, midpoint at elapsed p/2
  function automatic logic [PERIOD_W-1:0] mid_count(input logic [PERIOD_W-1:0] p);
    return last_count(p) - (eff_period(p) >> 1);
  endfunction

  logic [PERIOD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= last_count(period);
    end else if (run) begin
      cnt <= (cnt == '0) ? last_count(period) : cnt - PERIOD_W'(1);
    end
  end

  assign end_tick = run && (cnt == '0);
  assign mid_tick = run && (cnt == mid_count(period));

endmodule

// File: rtl/tx_abort_reg.sv
module tx_abort_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic busy,
  input  logic frame_over,
  output logic abort_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
    end else if (frame_over) begin
      abort_q <= 1'b0;
    end else if (wr && busy) begin
      abort_q <= wdata;
    end
  end

  AST_IDLE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !busy) |=> !abort_q); // R7

  AST_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_over |=> !abort_q); // R6

endmodule

// File: rtl/tx_err_flag.sv
module tx_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R9

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import resp_tx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             byte_load,
  input  logic [7:0]       byte_data,
  input  logic             abort_q,
  input  logic             mid_tick,
  input  logic             end_tick,
  input  logic             bus_in,
  output logic             tx_out,
  output logic             busy,
  output logic             byte_req,
  output logic             done,
  output logic             accept,
  output logic             shifting,
  output logic             err_set,
  output logic             frame_over
);

  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  tx_state_e             state, nxt;
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      bit_idx;
  logic [CNT_W-1:0]      remaining;
  logic                  err_pend;
  logic                  done_set, shift_en, cnt_dec, mismatch, err_now, begin_xfer;

  assign tx_out   = (state == ST_SHIFT) ? shreg[0] : 1'b1;
  assign busy     = (state != ST_IDLE);
  assign shifting = (state == ST_SHIFT);
  assign byte_req = (state == ST_WAIT) && !abort_q;

  assign mismatch = shifting && mid_tick && (bus_in != tx_out);
  assign err_now  = err_pend || mismatch;

  always_comb begin
    nxt        = state;
    accept     = 1'b0;
    done_set   = 1'b0;
    err_set    = 1'b0;
    shift_en   = 1'b0;
    cnt_dec    = 1'b0;
    begin_xfer = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && (byte_count != '0)) begin
          nxt        = ST_WAIT;
          begin_xfer = 1'b1;
        end
      end
      ST_WAIT: begin
        if (abort_q) begin
          nxt = ST_IDLE;
        end else if (byte_load) begin
          nxt    = ST_SHIFT;
          accept = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (end_tick) begin
          if (err_now) begin
            nxt     = ST_IDLE;
            err_set = 1'b1;
          end else if (bit_idx == LAST_BIT) begin
            if (abort_q) begin
              nxt = ST_IDLE;
            end else if (remaining == CNT_W'(1)) begin
              nxt      = ST_IDLE;
              done_set = 1'b1;
            end else begin
              nxt     = ST_WAIT;
              cnt_dec = 1'b1;
            end
          end else begin
            shift_en = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign frame_over = busy && (nxt == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '1;
      bit_idx   <= '0;
      remaining <= '0;
      err_pend  <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= nxt;
      if (begin_xfer) begin
        remaining <= byte_count;
        done      <= 1'b0;
      end
      if (accept) begin
        shreg    <= frame_word(byte_data);
        bit_idx  <= '0;
        err_pend <= 1'b0;
      end else if (shift_en) begin
        shreg    <= {1'b1, shreg[FRAME_BITS-1:1]};
        bit_idx  <= bit_idx + IDX_W'(1);
        err_pend <= err_pend || mismatch;
      end else if (mismatch) begin
        err_pend <= 1'b1;
      end
      if (cnt_dec)  remaining <= remaining - CNT_W'(1);
      if (done_set) done      <= 1'b1;
    end
  end

  AST_BIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (bit_idx <= LAST_BIT)); // R2

  AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> !done); // R8

endmodule

// File: rtl/resp_byte_tx.sv
module resp_byte_tx #(
  parameter int PERIOD_W = 16,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] bit_period,
  input  logic                start,
  input  logic [CNT_W-1:0]    byte_count,
  output logic                byte_req,
  input  logic                byte_load,
  input  logic [7:0]          byte_data,
  input  logic                abort_wr,
  input  logic                abort_wdata,
  output logic                abort_rd,
  input  logic                err_clr,
  output logic                bit_err,
  output logic                tx_done,
  output logic                tx_busy,
  output logic                tx_out,
  input  logic                bus_in
);

  // named internal events
  logic ev_accept, ev_shifting, ev_err_set, ev_frame_over;
  logic ev_mid_tick, ev_end_tick;

  tx_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept),
    .run      (ev_shifting),
    .period   (bit_period),
    .mid_tick (ev_mid_tick),
    .end_tick (ev_end_tick)
  );

  tx_frame_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .byte_load  (byte_load),
    .byte_data  (byte_data),
    .abort_q    (abort_rd),
    .mid_tick   (ev_mid_tick),
    .end_tick   (ev_end_tick),
    .bus_in     (bus_in),
    .tx_out     (tx_out),
    .busy       (tx_busy),
    .byte_req   (byte_req),
    .done       (tx_done),
    .accept     (ev_accept),
    .shifting   (ev_shifting),
    .err_set    (ev_err_set),
    .frame_over (ev_frame_over)
  );

  tx_abort_reg u_abort (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (abort_wr),
    .wdata      (abort_wdata),
    .busy       (tx_busy),
    .frame_over (ev_frame_over),
    .abort_q    (abort_rd)
  );

  tx_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_err_set),
    .clr   (err_clr),
    .flag  (bit_err)
  );

  AST_IDLE_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !abort_rd); // R7

  AST_START_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && byte_req) |=> !tx_out); // R2

  AST_WAIT_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> tx_out); // R3

  AST_DONE_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !$past(abort_rd)); // R6

  AST_ERR_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err) |-> (!tx_busy && $past(tx_busy))); // R8

endmodule

// File: tb/sim_resp_byte_tx.sv
`timescale 1ns/1ps
module sim_resp_byte_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bit_period = 16'd8;
  logic        start = 1'b0;
  logic [3:0]  byte_count = '0;
  logic        byte_req;
  logic        byte_load = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        abort_wr = 1'b0;
  logic        abort_wdata = 1'b0;
  logic        abort_rd;
  logic        err_clr = 1'b0;
  logic        bit_err, tx_done, tx_busy, tx_out;
  logic        force_low = 1'b0;
  logic        bus_in;

  assign bus_in = tx_out & ~force_low;

  resp_byte_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .start(start),
    .byte_count(byte_count), .byte_req(byte_req), .byte_load(byte_load),
    .byte_data(byte_data), .abort_wr(abort_wr), .abort_wdata(abort_wdata),
    .abort_rd(abort_rd), .err_clr(err_clr), .bit_err(bit_err),
    .tx_done(tx_done), .tx_busy(tx_busy), .tx_out(tx_out), .bus_in(bus_in)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_p    = 8;

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // byte supplier
  logic [7:0] feed_data [0:7];
  int feed_n = 0, feed_idx = 0, feed_gap = 0, gap_cnt = 0;
  int load_cyc [0:7];

  initial begin
    forever begin
      @(negedge clk);
      byte_load = 1'b0;
      if (byte_req && feed_idx < feed_n) begin
        if (gap_cnt < feed_gap) gap_cnt++;
        else begin
          byte_load = 1'b1;
          byte_data = feed_data[feed_idx];
          load_cyc[feed_idx] = cyc;
          feed_idx++;
          gap_cnt = 0;
        end
      end
    end
  end

  // bus monitor: decodes frames from tx_out at bit midpoints
  logic [7:0] mon_data [0:15];
  int mon_n = 0, mon_bad = 0;
  logic mon_prev = 1'b1;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !tx_out && mon_prev) begin
        logic [7:0] b;
        int p;
        p = cur_p;
        repeat (p / 2) @(negedge clk);
        if (tx_out !== 1'b0) mon_bad++;
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(negedge clk);
          b[i] = tx_out;
        end
        repeat (p) @(negedge clk);
        if (tx_out !== 1'b1) mon_bad++;
        if (mon_n < 16) mon_data[mon_n] = b;
        mon_n++;
      end
      mon_prev = tx_out;
    end
  end

  task automatic at_cycle(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic prep(input int p, input int n, input int gap);
    @(negedge clk);
    cur_p = p;
    bit_period = 16'(p);
    feed_n = n;
    feed_idx = 0;
    feed_gap = gap;
    gap_cnt = 0;
    mon_n = 0;
    mon_bad = 0;
  endtask

  task automatic kick(input int n);
    @(negedge clk);
    start = 1'b1;
    byte_count = 4'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_loaded(input int k);
    while (feed_idx < k) @(negedge clk);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (tx_busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) check_eq("R4 transfer never ended", 1, 0);
    repeat (12 * cur_p + 4) @(negedge clk);
  endtask

  task automatic abort_pulse();
    abort_wr = 1'b1;
    abort_wdata = 1'b1;
    @(negedge clk);
    abort_wr = 1'b0;
    abort_wdata = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1 tx_out", tx_out, 1);
    check_eq("R1 busy", tx_busy, 0);
    check_eq("R1 done", tx_done, 0);
    check_eq("R1 bit_err", bit_err, 0);
    check_eq("R1 abort_rd", abort_rd, 0);
    check_eq("R1 byte_req", byte_req, 0);
  endtask

  task automatic t_single();
    int c;
    prep(8, 1, 0);
    feed_data[0] = 8'h5B;
    kick(1);
    wait_loaded(1);
    c = load_cyc[0];
    at_cycle(c + 1);
    check_eq("R2 start bit low", tx_out, 0);
    at_cycle(c + 8);
    check_eq("R2 start bit last cycle", tx_out, 0);
    at_cycle(c + 9);
    check_eq("R2 data bit0 after one period", tx_out, 1);
    wait_idle();
    check_eq("R4 done after last byte", tx_done, 1);
    check_eq("R2 bytes on bus", mon_n, 1);
    check_eq("R2 byte value LSB first", mon_data[0], 8'h5B);
    check_eq("R2 framing", mon_bad, 0);
  endtask

  task automatic t_multi();
    prep(5, 3, 7);
    feed_data[0] = 8'h00; feed_data[1] = 8'hFF; feed_data[2] = 8'h3C;
    kick(3);
    check_eq("R4 done cleared by start", tx_done, 0);
    check_eq("R3 busy after start", tx_busy, 1);
    wait_loaded(1);
    @(negedge clk);
    start = 1'b1;
    byte_count = 4'd6;
    @(negedge clk);
    start = 1'b0;
    while (!byte_req && tx_busy) @(negedge clk);
    check_eq("R3 line recessive while waiting", tx_out, 1);
    wait_idle();
    check_eq("R3 byte count honoured", mon_n, 3);
    check_eq("R3 byte 0", mon_data[0], 8'h00);
    check_eq("R3 byte 1", mon_data[1], 8'hFF);
    check_eq("R3 byte 2", mon_data[2], 8'h3C);
    check_eq("R4 done", tx_done, 1);
  endtask

  task automatic t_zero();
    prep(4, 0, 0);
    kick(0);
    check_eq("R3 zero count ignored", tx_busy, 0);
    check_eq("R3 no request on zero count", byte_req, 0);
  endtask

  task automatic t_abort_mid();
    int c;
    prep(6, 4, 0);
    feed_data[0] = 8'h11; feed_data[1] = 8'h22;
    feed_data[2] = 8'h33; feed_data[3] = 8'h44;
    kick(4);
    wait_loaded(2);
    c = load_cyc[1];
    at_cycle(c + 1 + 3 * 6);
    abort_pulse();
    check_eq("R6 abort reads 1 while pending", abort_rd, 1);
    at_cycle(c + 1 + 10 * 6 - 1);
    check_eq("R5 byte finishes before stop", tx_busy, 1);
    at_cycle(c + 1 + 10 * 6);
    check_eq("R5 stop at byte boundary", tx_busy, 0);
    wait_idle();
    check_eq("R5 bytes sent", mon_n, 2);
    check_eq("R5 aborted byte complete", mon_data[1], 8'h22);
    check_eq("R6 abort self-cleared", abort_rd, 0);
    check_eq("R6 no done on abort", tx_done, 0);
    check_eq("R6 remaining not requested", feed_idx, 2);
  endtask

  task automatic t_abort_idle();
    prep(4, 1, 0);
    feed_data[0] = 8'hC3;
    @(negedge clk);
    abort_pulse();
    check_eq("R7 idle write reads 0", abort_rd, 0);
    kick(1);
    wait_idle();
    check_eq("R7 following transfer done", tx_done, 1);
    check_eq("R7 following byte", mon_data[0], 8'hC3);
  endtask

  task automatic t_boundary();
    int c;
    prep(4, 3, 0);
    feed_data[0] = 8'hA1; feed_data[1] = 8'hB2; feed_data[2] = 8'hC4;
    kick(3);
    wait_loaded(1);
    c = load_cyc[0];
    at_cycle(c + 10 * 4);
    abort_pulse();
    wait_idle();
    check_eq("R10 one byte sent", mon_n, 1);
    check_eq("R10 next byte not requested", feed_idx, 1);
    check_eq("R10 no done", tx_done, 0);
    check_eq("R10 abort cleared", abort_rd, 0);

    prep(4, 1, 0);
    feed_data[0] = 8'h96;
    kick(1);
    wait_loaded(1);
    c = load_cyc[0];
    at_cycle(c + 10 * 4);
    abort_pulse();
    wait_idle();
    check_eq("R10 last byte completes with done", tx_done, 1);
    check_eq("R10 last byte value", mon_data[0], 8'h96);
    check_eq("R10 abort reads 0 after end", abort_rd, 0);
  endtask

  task automatic t_biterr();
    int c;
    prep(8, 2, 0);
    feed_data[0] = 8'hFF; feed_data[1] = 8'h00;
    kick(2);
    wait_loaded(1);
    c = load_cyc[0];
    at_cycle(c + 1 + 2 * 8);
    force_low = 1'b1;
    at_cycle(c + 1 + 3 * 8 - 1);
    check_eq("R8 bit still in progress", tx_busy, 1);
    at_cycle(c + 1 + 3 * 8);
    force_low = 1'b0;
    check_eq("R8 stop at end of bit", tx_busy, 0);
    check_eq("R8 bit_err set", bit_err, 1);
    check_eq("R8 bus released", tx_out, 1);
    wait_idle();
    check_eq("R8 no done", tx_done, 0);
    check_eq("R8 no more bytes requested", feed_idx, 1);
    check_eq("R9 error sticky", bit_err, 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check_eq("R9 cleared by write 1", bit_err, 0);

    prep(4, 1, 0);
    feed_data[0] = 8'h00;
    kick(1);
    wait_loaded(1);
    c = load_cyc[0];
    at_cycle(c + 1 + 9 * 4);
    force_low = 1'b1;
    at_cycle(c + 1 + 10 * 4);
    force_low = 1'b0;
    wait_idle();
    check_eq("R8 stop-bit error flagged", bit_err, 1);
    check_eq("R8 stop-bit error no done", tx_done, 0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_zero();
    t_abort_mid();
    t_abort_idle();
    t_boundary();
    t_biterr();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule